// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This unit forms the memory address that a load or store will use. It takes a base value, an index value with its own enable, a two-bit scale code and a signed displacement. The index is multiplied by 1, 2, 4 or 8 using a left shift, so no multiplier is needed. The three terms are added modulo 2^N, where N is the address width. The displacement is sign-extended to N bits before the addition.

The sum never raises an arithmetic fault. When the exact sum falls outside the address range, the result wraps around and is passed on as an ordinary valid address. A separate wrap flag reports that this happened. Translation, fault checks and the memory access itself belong to later stages.

Operands enter on a valid/ready handshake. The result and its wrap flag come out of a single output register on the next clock edge. That register keeps its value for as long as the consumer holds ready low.

Top module: `agen_unit`

## Requirements
- R1: `out_addr` equals (base + scaled index term + sign-extended displacement) mod 2^N.
- R2: Scale code 0, 1, 2 or 3 multiplies the index by 1, 2, 4 or 8, which is a left shift by the code value. The shifted index keeps only its low N bits.
- R3: While `in_idx_en` is 0, the index term is zero and the value on `in_index` has no effect on `out_addr` or `out_wrap`.
- R4: `out_wrap` is 1 exactly when the unwrapped sum lies outside 0 .. 2^N-1. With the index disabled:
  - for a displacement of zero or more, the flag equals (result < base);
  - for a negative displacement, it equals (result > base).
- R5: A wrapped result is delivered with `out_valid` high, like any other address. The unit has no fault or exception output.
- R6: An operand set accepted at a clock edge (`in_valid` and `in_ready` both high) appears on `out_addr` and `out_wrap`, with `out_valid` high, right after that edge.
- R7: `in_ready` is high when the output register is empty or is being consumed. While `out_valid` is high and `out_ready` is low:
  - `in_ready` is low;
  - `out_addr` and `out_wrap` hold their values.
- R8: While `rst_n` is low, `out_valid` is 0 after each clock edge.
- R9: `out_valid` falls after an edge where the result is consumed and no new operand set is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set is offered |
| in_ready | output | 1 | Unit can accept an operand set |
| in_base | input | N | Base value |
| in_index | input | N | Index value |
| in_idx_en | input | 1 | 1 = use the index term |
| in_scale | input | 2 | Scale code: index shifted left by this amount |
| in_disp | input | D | Signed displacement, two's complement |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | N | Effective address |
| out_wrap | output | 1 | Unwrapped sum was out of range |

## Verification
The wrap detection and the output stall can fall in the same cycle. A wrapped result can sit in the output register while the consumer holds ready low and a new operand set waits at the input. The bench provokes this directly: it sends a wrapping address with `out_ready` low, then offers a second, non-wrapping set. It judges that the first address and its wrap flag stay unchanged, that `in_ready` stays low, and that the second set comes out with a clear flag only after ready returns. Random vectors that include top-of-range bases and negative displacements cover the rest of the arithmetic against a wide-integer model in the bench.

// File: rtl/agen_pkg.sv
`timescale 1ns/1ps
package agen_pkg;
  // Scale code: index is shifted left by the code value.
  typedef enum logic [1:0] {
    SCL_X1 = 2'd0,
    SCL_X2 = 2'd1,
    SCL_X4 = 2'd2,
    SCL_X8 = 2'd3
  } scale_e;

  localparam int unsigned SCALE_CODES = 4;
  // Extra sum bits needed to hold the unwrapped base + index + displacement.
  localparam int unsigned GUARD_BITS = 3;
endpackage

// File: rtl/agen_scaler.sv
`timescale 1ns/1ps
module agen_scaler #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0]     index,
  input  logic             idx_en,
  input  agen_pkg::scale_e scale,
  output logic [N-1:0]     term
);
  import agen_pkg::*;

  logic [N-1:0] shifted [SCALE_CODES];

  // One candidate per scale code; the shift discards bits above N.
  for (genvar g = 0; g < SCALE_CODES; g++) begin : g_shift
    assign shifted[g] = index << g;
  end

  always_comb begin
    term = '0;
    if (idx_en) term = shifted[scale];
  end
endmodule

// File: rtl/agen_adder.sv
`timescale 1ns/1ps
module agen_adder #(
  parameter int unsigned N = 32,
  parameter int unsigned D = 16
) (
  input  logic [N-1:0] base,
  input  logic [N-1:0] term,
  input  logic [D-1:0] disp,
  output logic [N-1:0] ea,
  output logic         wrap,
  output logic         disp_neg
);
  import agen_pkg::*;

  localparam int unsigned W = N + GUARD_BITS;

  // Signed wide sum with no loss; a result outside 0 .. 2^N-1 means a wrap.
  function automatic logic signed [W-1:0] exact_sum(
    input logic [N-1:0] b,
    input logic [N-1:0] t,
    input logic [D-1:0] d
  );
    logic signed [W-1:0] bw, tw, dw;
    bw = $signed({{GUARD_BITS{1'b0}}, b});
    tw = $signed({{GUARD_BITS{1'b0}}, t});
    dw = $signed({{(W-D){d[D-1]}}, d});
    return bw + tw + dw;
  endfunction

  function automatic logic out_of_range(input logic signed [W-1:0] s);
    return s[W-1:N] != '0;
  endfunction

  logic signed [W-1:0] sum_w;

  always_comb begin
    sum_w    = exact_sum(base, term, disp);
    ea       = sum_w[N-1:0];
    wrap     = out_of_range(sum_w);
    disp_neg = disp[D-1];
  end
endmodule

// File: rtl/agen_stage.sv
`timescale 1ns/1ps
module agen_stage #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [N-1:0] d_addr,
  input  logic         d_wrap,
  output logic         q_valid,
  input  logic         q_ready,
  output logic [N-1:0] q_addr,
  output logic         q_wrap
);
  assign up_ready = !q_valid || q_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
    end else if (up_ready) begin
      q_valid <= up_valid;
    end
  end

  // Data register loads only on acceptance, so a stalled result holds still.
  always_ff @(posedge clk) begin
    if (up_ready && up_valid) begin
      q_addr <= d_addr;
      q_wrap <= d_wrap;
    end
  end
endmodule

// File: rtl/agen_unit.sv
`timescale 1ns/1ps
module agen_unit #(
  parameter int unsigned N = 32,
  parameter int unsigned D = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_base,
  input  logic [N-1:0] in_index,
  input  logic         in_idx_en,
  input  logic [1:0]   in_scale,
  input  logic [D-1:0] in_disp,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_addr,
  output logic         out_wrap
);
  import agen_pkg::*;

  // Named internal events, brought out for the checker.
  logic [N-1:0] idx_term;
  logic [N-1:0] ea_next;
  logic         wrap_next;
  logic         disp_neg;

  agen_scaler #(.N(N)) u_scale (
    .index (in_index),
    .idx_en(in_idx_en),
    .scale (scale_e'(in_scale)),
    .term  (idx_term)
  );

  agen_adder #(.N(N), .D(D)) u_add (
    .base    (in_base),
    .term    (idx_term),
    .disp    (in_disp),
    .ea      (ea_next),
    .wrap    (wrap_next),
    .disp_neg(disp_neg)
  );

  agen_stage #(.N(N)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_valid(in_valid),
    .up_ready(in_ready),
    .d_addr  (ea_next),
    .d_wrap  (wrap_next),
    .q_valid (out_valid),
    .q_ready (out_ready),
    .q_addr  (out_addr),
    .q_wrap  (out_wrap)
  );
endmodule

// File: rtl/agen_unit_chk.sv
`timescale 1ns/1ps
module agen_unit_chk #(
  parameter int unsigned N = 32,
  parameter int unsigned D = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [N-1:0] in_base,
  input logic         in_idx_en,
  input logic         out_valid,
  input logic         out_ready,
  input logic [N-1:0] out_addr,
  input logic         out_wrap,
  input logic [N-1:0] idx_term,
  input logic [N-1:0] ea_next,
  input logic         wrap_next,
  input logic         disp_neg
);
  assert_reset_clears_R8: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_index_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_idx_en |-> idx_term == '0);

  assert_wrap_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_idx_en && !disp_neg |-> wrap_next == (ea_next < in_base));

  assert_wrap_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_idx_en && disp_neg |-> wrap_next == (ea_next > in_base));

  assert_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_addr == $past(ea_next)
                              && out_wrap == $past(wrap_next));

  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_wrap));

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

bind agen_unit agen_unit_chk #(.N(N), .D(D)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_base  (in_base),
  .in_idx_en(in_idx_en),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_addr (out_addr),
  .out_wrap (out_wrap),
  .idx_term (idx_term),
  .ea_next  (ea_next),
  .wrap_next(wrap_next),
  .disp_neg (disp_neg)
);

// File: tb/sim_agen_unit.sv
`timescale 1ns/1ps
module sim_agen_unit;
  localparam int unsigned N = 32;
  localparam int unsigned D = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [N-1:0] in_base = '0;
  logic [N-1:0] in_index = '0;
  logic         in_idx_en = 1'b0;
  logic [1:0]   in_scale = '0;
  logic [D-1:0] in_disp = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [N-1:0] out_addr;
  logic         out_wrap;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  agen_unit #(.N(N), .D(D)) u0 (.*);

  // Model, written as integer arithmetic on 64-bit values.
  function automatic longint unsigned model_term(
    input logic [N-1:0] idx, input logic en, input logic [1:0] sc);
    longint unsigned v;
    if (!en) return 0;
    v = longint'(idx) * (64'd1 << sc);
    return v % (64'd1 << N);
  endfunction

  function automatic longint model_exact(
    input logic [N-1:0] b, input logic [N-1:0] idx, input logic en,
    input logic [1:0] sc, input logic [D-1:0] d);
    return longint'(b) + longint'(model_term(idx, en, sc)) + longint'($signed(d));
  endfunction

  task automatic check(input bit ok, input string req, input longint got, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  // Offer one operand set with out_ready high; check the result one edge later.
  task automatic send(input logic [N-1:0] b, input logic [N-1:0] idx, input logic en,
                      input logic [1:0] sc, input logic [D-1:0] d, input string req);
    longint ex;
    logic [N-1:0] ea;
    logic wr;
    ex = model_exact(b, idx, en, sc, d);
    ea = ex[N-1:0];
    wr = (ex < 0) || (ex >= (longint'(1) << N));
    @(negedge clk);
    in_base = b; in_index = idx; in_idx_en = en; in_scale = sc; in_disp = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, {req, " R5/R6 valid"}, longint'(out_valid), 1);
    check(out_addr === ea, {req, " R1 addr"}, longint'(out_addr), longint'(ea));
    check(out_wrap === wr, {req, " R4 wrap"}, longint'(out_wrap), longint'(wr));
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired got=0 expected=1");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R8: reset state
    check(out_valid === 1'b0, "R8 out_valid in reset", longint'(out_valid), 0);
    check(in_ready === 1'b1, "R8/R7 in_ready in reset", longint'(in_ready), 1);
    rst_n = 1'b1;

    // Directed corner cases
    send(32'hFFFF_FFFE, 32'h0, 1'b0, 2'd0, 16'd5, "R1 top wrap");
    send(32'h7FFF_FFF0, 32'h0, 1'b0, 2'd0, 16'h0030, "R5 sign-crossing no wrap");
    send(32'h0000_0010, 32'h0, 1'b0, 2'd0, 16'hFFE0, "R4 negative wrap");
    send(32'h0000_1000, 32'hFFFF, 1'b0, 2'd3, 16'h0, "R3 index ignored");
    send(32'h0000_1000, 32'h10, 1'b1, 2'd0, 16'h4, "R2 scale x1");
    send(32'h0000_1000, 32'h10, 1'b1, 2'd1, 16'h4, "R2 scale x2");
    send(32'h0000_1000, 32'h10, 1'b1, 2'd2, 16'h4, "R2 scale x4");
    send(32'h0000_1000, 32'h10, 1'b1, 2'd3, 16'hFFFC, "R2 scale x8");
    send(32'h0000_0100, 32'hF000_0001, 1'b1, 2'd3, 16'h0, "R2 shift truncation");
    send(32'hF000_0000, 32'h2000_0000, 1'b1, 2'd0, 16'hFFF0, "R4 index wrap");

    // R9: consumed and nothing offered, valid drops
    @(negedge clk);
    check(out_valid === 1'b0, "R9 drain", longint'(out_valid), 0);

    // R7: stall with a wrapped result held while a second set waits
    @(negedge clk);
    out_ready = 1'b0;
    in_base = 32'hFFFF_FFF0; in_index = '0; in_idx_en = 1'b0; in_scale = '0;
    in_disp = 16'h0020; in_valid = 1'b1;
    @(negedge clk);
    in_base = 32'h0000_2000; in_disp = 16'h0008;
    repeat (3) begin
      @(negedge clk);
      check(in_ready === 1'b0, "R7 ready low in stall", longint'(in_ready), 0);
      check(out_addr === 32'h0000_0010 && out_wrap === 1'b1, "R7 held result",
            longint'(out_addr), 64'h10);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_addr === 32'h0000_2008 && out_wrap === 1'b0,
          "R6/R7 second set after release", longint'(out_addr), 64'h2008);
    @(negedge clk);

    // Random vectors, some biased toward the top of the range
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] b;
      b = $urandom;
      if (i % 4 == 0) b = 32'hFFFF_0000 | b[15:0];
      send(b, $urandom, ($urandom % 4) != 0, 2'($urandom), 16'($urandom), "R1 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule